// File: doc/BRIEF.md
# Layered Pixel Blend Chain

This block merges pixel streams from several plane sources into one pixel per output pipe. It holds a pool of blend stages. Each stage picks one plane source as its top layer and may point at another stage as its bottom layer. The bottom pointers link the stages into a stack of any order. A stage whose bottom link is open blends over its own programmed background colour. A per-pipe output selector picks the stage that heads the stack for that pipe. In every 4-bit select field the value 0xF means "not connected".

Each stage registers its result once, so a pixel gains one cycle of latency for every stage it passes through. Software programs the stages through a small write port with a combinational read-back. The fields are the top and bottom selects, the blend mode, the alpha source, a premultiplied flag, an overlap-only flag, an 8-bit global alpha, an 8-bit global gain, the output-pipe id, the lock select and the background colour. Each stage also reports an idle bit and a busy bit.

Top module: `blend_chain`

## Requirements
- R1: A write with `cfg_we` stores `cfg_wdata` into the field named by `cfg_field` for stage (or pipe) `cfg_index`, and `cfg_rdata` returns the stored value in the same bit layout. The field codes and layouts are:
  - 0: top select in [3:0].
  - 1: bottom select in [3:0].
  - 2: control, with mode in [1:0], alpha source in [3:2], premultiplied in [4] and overlap-only in [5].
  - 3: global alpha in [7:0] and global gain in [15:8].
  - 4: pipe id in [3:0] and lock select in [7:4].
  - 5: background, with 10-bit R/Cr in [29:20], G/Y in [19:10] and B/Cb in [9:0].
  - 6: output selector of pipe `cfg_index` in [3:0].
- R2: After reset, every select, pipe id, lock select and output selector reads 0xF. Global alpha and global gain read 0xFF. Control reads 0 (mode 0, alpha source 0, both flags clear). The background reads 0.
- R3: The background is held as 12-bit components equal to the written 10-bit values shifted left by 2. A stage with no valid contribution outputs its background with its valid low.
- R4: In mode 0 (top only), a stage with a valid top pixel outputs the top blended over its background, with valid high, one clock after the source pixel is presented.
- R5: In mode 1 (top over bottom), when both the top pixel and the selected bottom stage are valid, the output is the top blended over that bottom stage's registered output.
- R6: A bottom select equal to the stage's own index, equal to 0xF, or at least the stage count counts as disconnected. A mode-1 stage then blends its top over its background.
- R7: In mode 2 (passthrough), and in the spare code 3, a valid top pixel passes through unchanged.
- R8: The blend for each component is floor((a·top + (255−a)·bottom)/255), saturated to 4095. In premultiplied mode the top term is top·255. The alpha `a` depends on the alpha source: 0 uses the pixel alpha, 1 uses the global alpha, 2 uses floor(pixel alpha·global gain/255), and 3 uses the pixel alpha.
- R9: In mode 1 with overlap-only set, a valid top pixel over an invalid or disconnected bottom passes unchanged.
- R10: In mode 1, an invalid top over a valid bottom outputs the bottom stage's colour with valid high.
- R11: Output pipe p shows the valid bit and colour of the stage its selector names. A selector of 0xF, or of at least the stage count, gives valid low and colour 0.
- R12: A stage's busy bit is high when its top select is connected and it accepted a valid top pixel at the previous clock edge. Idle is always the inverse of busy, so a stage whose top select is 0xF reports idle=1 and busy=0 at once.
- R13: A top select at or above the source count counts as disconnected, the same as 0xF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_field | input | 3 | Field code (see R1) |
| cfg_index | input | 4 | Stage index, or pipe index for field 6 |
| cfg_wdata | input | 30 | Write data |
| cfg_rdata | output | 30 | Read-back of the addressed field |
| src_vld | input | N_SRC | Per-source pixel valid |
| src_alpha | input | 8*N_SRC | Per-source 8-bit alpha |
| src_rgb | input | 36*N_SRC | Per-source colour {R,G,B}, 12 bits each |
| out_vld | output | N_OUT | Per-pipe output valid |
| out_rgb | output | 36*N_OUT | Per-pipe output colour {R,G,B} |
| stat_idle | output | N_STAGE | Per-stage idle flag |
| stat_busy | output | N_STAGE | Per-stage busy flag |

## Verification
The bench builds the block with 4 stages, 4 sources and 2 output pipes. With these values, the 4-bit select fields can reach every distinct case. Top selects of 4 and 5 lie past the source count. A bottom select of 9 and output selectors of 4, 5 and 9 lie past the stage count. 0xF and self-links are reachable as well. Random acyclic stacks up to four stages deep exercise the per-level latency and the settled result of every mode and alpha source.

// File: rtl/blend_chain_pkg.sv
package blend_chain_pkg;

    localparam int CW   = 12;
    localparam int AW   = 8;
    localparam int SELW = 4;
    localparam int DW   = 30;
    localparam logic [SELW-1:0] SEL_OFF = 4'hF;

    typedef struct packed {
        logic [CW-1:0] r;
        logic [CW-1:0] g;
        logic [CW-1:0] b;
    } rgb_t;

    typedef enum logic [1:0] {
        MD_TOP  = 2'd0,
        MD_MIX  = 2'd1,
        MD_PASS = 2'd2,
        MD_SPR  = 2'd3
    } blend_mode_e;

    typedef enum logic [2:0] {
        FLD_TOP  = 3'd0,
        FLD_BOT  = 3'd1,
        FLD_CTRL = 3'd2,
        FLD_GAIN = 3'd3,
        FLD_PIPE = 3'd4,
        FLD_BG   = 3'd5,
        FLD_OMUX = 3'd6,
        FLD_NONE = 3'd7
    } cfg_field_e;

    typedef struct packed {
        logic [SELW-1:0] top_sel;
        logic [SELW-1:0] bot_sel;
        blend_mode_e     mode;
        logic [1:0]      amode;
        logic            premul;
        logic            ovl;
        logic [AW-1:0]   galpha;
        logic [AW-1:0]   ggain;
        logic [SELW-1:0] pipe_id;
        logic [SELW-1:0] lock_sel;
        rgb_t            bg;
    } stage_cfg_t;

    localparam stage_cfg_t STAGE_RST = '{
        top_sel:  SEL_OFF,
        bot_sel:  SEL_OFF,
        mode:     MD_TOP,
        amode:    2'd0,
        premul:   1'b0,
        ovl:      1'b0,
        galpha:   8'hFF,
        ggain:    8'hFF,
        pipe_id:  SEL_OFF,
        lock_sel: SEL_OFF,
        bg:       '0
    };

    // Effective alpha from the per-stage alpha source selection.
    function automatic logic [AW-1:0] eff_alpha(input logic [1:0] am, input logic [AW-1:0] pa,
                                                input logic [AW-1:0] ga, input logic [AW-1:0] gg);
        logic [15:0] prod;
        prod = {8'd0, pa} * {8'd0, gg};
        unique case (am)
            2'd1:    return ga;
            2'd2:    return 8'(prod / 16'd255);
            default: return pa;
        endcase
    endfunction

    // One colour component: floor((a*t + (255-a)*b)/255), saturated.
    function automatic logic [CW-1:0] mix_c(input logic [CW-1:0] t, input logic [CW-1:0] b,
                                            input logic [AW-1:0] a, input logic pm);
        logic [21:0] tt, bb, q;
        tt = pm ? ({10'd0, t} * 22'd255) : ({10'd0, t} * {14'd0, a});
        bb = {10'd0, b} * {14'd0, 8'd255 - a};
        q  = (tt + bb) / 22'd255;
        return (q > 22'd4095) ? 12'hFFF : q[CW-1:0];
    endfunction

    function automatic rgb_t mix_rgb(input rgb_t t, input rgb_t b, input logic [AW-1:0] a,
                                     input logic pm);
        rgb_t o;
        o.r = mix_c(t.r, b.r, a, pm);
        o.g = mix_c(t.g, b.g, a, pm);
        o.b = mix_c(t.b, b.b, a, pm);
        return o;
    endfunction

endpackage

// File: rtl/blend_chain_regs.sv
module blend_chain_regs
    import blend_chain_pkg::*;
#(
    parameter int N_STAGE = 4,
    parameter int N_OUT   = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [2:0]                     field,
    input  logic [SELW-1:0]                index,
    input  logic [DW-1:0]                  wdata,
    output logic [DW-1:0]                  rdata,
    output stage_cfg_t [N_STAGE-1:0]       cfg_all,
    output logic [N_OUT-1:0][SELW-1:0]     omux
);

    typedef struct packed {
        stage_cfg_t [N_STAGE-1:0]   st;
        logic [N_OUT-1:0][SELW-1:0] om;
    } regs_t;

    regs_t r_d, r_q;

    logic st_hit, om_hit;
    assign st_hit = int'(index) < N_STAGE;
    assign om_hit = int'(index) < N_OUT;

    always_comb begin
        r_d = r_q;
        if (we) begin
            unique case (cfg_field_e'(field))
                FLD_TOP:  if (st_hit) r_d.st[index].top_sel = wdata[3:0];
                FLD_BOT:  if (st_hit) r_d.st[index].bot_sel = wdata[3:0];
                FLD_CTRL: if (st_hit) begin
                    r_d.st[index].mode   = blend_mode_e'(wdata[1:0]);
                    r_d.st[index].amode  = wdata[3:2];
                    r_d.st[index].premul = wdata[4];
                    r_d.st[index].ovl    = wdata[5];
                end
                FLD_GAIN: if (st_hit) begin
                    r_d.st[index].galpha = wdata[7:0];
                    r_d.st[index].ggain  = wdata[15:8];
                end
                FLD_PIPE: if (st_hit) begin
                    r_d.st[index].pipe_id  = wdata[3:0];
                    r_d.st[index].lock_sel = wdata[7:4];
                end
                FLD_BG: if (st_hit) begin
                    r_d.st[index].bg.r = {wdata[29:20], 2'b00};
                    r_d.st[index].bg.g = {wdata[19:10], 2'b00};
                    r_d.st[index].bg.b = {wdata[9:0],   2'b00};
                end
                FLD_OMUX: if (om_hit) r_d.om[index] = wdata[3:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < N_STAGE; k++) r_q.st[k] <= STAGE_RST;
            r_q.om <= {N_OUT{SEL_OFF}};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (cfg_field_e'(field))
            FLD_TOP:  if (st_hit) rdata = {26'd0, r_q.st[index].top_sel};
            FLD_BOT:  if (st_hit) rdata = {26'd0, r_q.st[index].bot_sel};
            FLD_CTRL: if (st_hit) rdata = {24'd0, r_q.st[index].ovl, r_q.st[index].premul,
                                           r_q.st[index].amode, r_q.st[index].mode};
            FLD_GAIN: if (st_hit) rdata = {14'd0, r_q.st[index].ggain, r_q.st[index].galpha};
            FLD_PIPE: if (st_hit) rdata = {22'd0, r_q.st[index].lock_sel, r_q.st[index].pipe_id};
            FLD_BG:   if (st_hit) rdata = {r_q.st[index].bg.r[11:2], r_q.st[index].bg.g[11:2],
                                           r_q.st[index].bg.b[11:2]};
            FLD_OMUX: if (om_hit) rdata = {26'd0, r_q.om[index]};
            default: ;
        endcase
    end

    assign cfg_all = r_q.st;
    assign omux    = r_q.om;

endmodule

// File: rtl/blend_chain_stage.sv
module blend_chain_stage
    import blend_chain_pkg::*;
#(
    parameter int N_STAGE = 4,
    parameter int N_SRC   = 4,
    parameter int IDX     = 0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  stage_cfg_t                    cfg,
    input  logic [N_SRC-1:0]              src_vld,
    input  logic [N_SRC-1:0][AW-1:0]      src_a,
    input  rgb_t [N_SRC-1:0]              src_c,
    input  logic [N_STAGE-1:0]            all_vld,
    input  rgb_t [N_STAGE-1:0]            all_rgb,
    output logic                          o_vld,
    output rgb_t                          o_rgb,
    output logic                          o_busy
);

    typedef struct packed {
        logic vld;
        rgb_t rgb;
        logic busy;
    } st_t;

    st_t s_d, s_q;

    logic          top_conn, top_ok, bot_conn, bot_ok;
    logic [AW-1:0] a;
    rgb_t          top_c, bot_c, over_bot, over_bg;
    logic          unused_cfg;

    assign unused_cfg = ^{cfg.pipe_id, cfg.lock_sel};

    always_comb begin
        top_conn = int'(cfg.top_sel) < N_SRC;
        bot_conn = (int'(cfg.bot_sel) < N_STAGE) && (int'(cfg.bot_sel) != IDX);
        top_ok   = top_conn && src_vld[cfg.top_sel];
        bot_ok   = bot_conn && all_vld[cfg.bot_sel];
        top_c    = top_conn ? src_c[cfg.top_sel] : '0;
        bot_c    = bot_conn ? all_rgb[cfg.bot_sel] : '0;
        a        = eff_alpha(cfg.amode, top_conn ? src_a[cfg.top_sel] : 8'd0,
                             cfg.galpha, cfg.ggain);
        over_bot = mix_rgb(top_c, bot_c, a, cfg.premul);
        over_bg  = mix_rgb(top_c, cfg.bg, a, cfg.premul);

        s_d.busy = top_ok;
        s_d.vld  = 1'b0;
        s_d.rgb  = cfg.bg;
        unique case (cfg.mode)
            MD_TOP: if (top_ok) begin
                s_d.vld = 1'b1;
                s_d.rgb = over_bg;
            end
            MD_MIX: begin
                if (top_ok && bot_ok) begin
                    s_d.vld = 1'b1;
                    s_d.rgb = over_bot;
                end else if (top_ok) begin
                    s_d.vld = 1'b1;
                    s_d.rgb = cfg.ovl ? top_c : over_bg;
                end else if (bot_ok) begin
                    s_d.vld = 1'b1;
                    s_d.rgb = bot_c;
                end
            end
            default: if (top_ok) begin
                s_d.vld = 1'b1;
                s_d.rgb = top_c;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign o_vld  = s_q.vld;
    assign o_rgb  = s_q.rgb;
    assign o_busy = s_q.busy && top_conn;

endmodule

// File: rtl/blend_chain_outmux.sv
module blend_chain_outmux
    import blend_chain_pkg::*;
#(
    parameter int N_STAGE = 4,
    parameter int N_OUT   = 2
) (
    input  logic [N_STAGE-1:0]           st_vld,
    input  rgb_t [N_STAGE-1:0]           st_rgb,
    input  logic [N_OUT-1:0][SELW-1:0]   omux,
    output logic [N_OUT-1:0]             out_vld,
    output rgb_t [N_OUT-1:0]             out_rgb
);

    for (genvar p = 0; p < N_OUT; p++) begin : g_pipe
        logic hit;
        assign hit        = int'(omux[p]) < N_STAGE;
        assign out_vld[p] = hit && st_vld[omux[p]];
        assign out_rgb[p] = hit ? st_rgb[omux[p]] : '0;
    end

endmodule

// File: rtl/blend_chain.sv
module blend_chain
    import blend_chain_pkg::*;
#(
    parameter int N_STAGE = 4,
    parameter int N_SRC   = 4,
    parameter int N_OUT   = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [2:0]             cfg_field,
    input  logic [3:0]             cfg_index,
    input  logic [29:0]            cfg_wdata,
    output logic [29:0]            cfg_rdata,
    input  logic [N_SRC-1:0]       src_vld,
    input  logic [8*N_SRC-1:0]     src_alpha,
    input  logic [36*N_SRC-1:0]    src_rgb,
    output logic [N_OUT-1:0]       out_vld,
    output logic [36*N_OUT-1:0]    out_rgb,
    output logic [N_STAGE-1:0]     stat_idle,
    output logic [N_STAGE-1:0]     stat_busy
);

    stage_cfg_t [N_STAGE-1:0]       cfg_all;
    logic [N_OUT-1:0][SELW-1:0]     omux_sel;
    logic [N_STAGE-1:0]             st_vld;
    rgb_t [N_STAGE-1:0]             st_rgb;
    logic [N_STAGE-1:0]             st_busy;
    logic [N_SRC-1:0][AW-1:0]       src_a;
    rgb_t [N_SRC-1:0]               src_c;
    rgb_t [N_OUT-1:0]               o_rgb;

    assign src_a = src_alpha;
    assign src_c = src_rgb;

    blend_chain_regs #(.N_STAGE(N_STAGE), .N_OUT(N_OUT)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .field   (cfg_field),
        .index   (cfg_index),
        .wdata   (cfg_wdata),
        .rdata   (cfg_rdata),
        .cfg_all (cfg_all),
        .omux    (omux_sel)
    );

    for (genvar k = 0; k < N_STAGE; k++) begin : g_stage
        blend_chain_stage #(.N_STAGE(N_STAGE), .N_SRC(N_SRC), .IDX(k)) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .cfg     (cfg_all[k]),
            .src_vld (src_vld),
            .src_a   (src_a),
            .src_c   (src_c),
            .all_vld (st_vld),
            .all_rgb (st_rgb),
            .o_vld   (st_vld[k]),
            .o_rgb   (st_rgb[k]),
            .o_busy  (st_busy[k])
        );
    end

    blend_chain_outmux #(.N_STAGE(N_STAGE), .N_OUT(N_OUT)) u_omux (
        .st_vld  (st_vld),
        .st_rgb  (st_rgb),
        .omux    (omux_sel),
        .out_vld (out_vld),
        .out_rgb (o_rgb)
    );

    assign out_rgb   = o_rgb;
    assign stat_busy = st_busy;
    assign stat_idle = ~st_busy;

endmodule

// File: rtl/blend_chain_chk.sv
module blend_chain_chk
    import blend_chain_pkg::*;
#(
    parameter int N_STAGE = 4,
    parameter int N_SRC   = 4,
    parameter int N_OUT   = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         cfg_we,
    input logic [2:0]                   cfg_field,
    input logic [3:0]                   cfg_index,
    input logic [29:0]                  cfg_wdata,
    input stage_cfg_t [N_STAGE-1:0]     cfg_all,
    input logic [N_OUT-1:0][SELW-1:0]   omux_sel,
    input logic [N_SRC-1:0]             src_vld,
    input logic [N_OUT-1:0]             out_vld,
    input logic [36*N_OUT-1:0]          out_rgb,
    input logic [N_STAGE-1:0]           stat_idle,
    input logic [N_STAGE-1:0]           stat_busy
);

    p_status_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        stat_idle == ~stat_busy);

    p_wr_top_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_field == 3'd0 && int'(cfg_index) < N_STAGE)
        |=> cfg_all[$past(cfg_index)].top_sel == $past(cfg_wdata[3:0]));

    p_rst_defaults_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cfg_all[0].top_sel == SEL_OFF && cfg_all[0].bot_sel == SEL_OFF
                          && cfg_all[0].galpha == 8'hFF && cfg_all[0].ggain == 8'hFF
                          && !cfg_all[0].ovl && omux_sel[0] == SEL_OFF));

    for (genvar k = 0; k < N_STAGE; k++) begin : g_st
        p_idle_disc_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_all[k].top_sel == SEL_OFF) |-> (stat_idle[k] && !stat_busy[k]));
        p_busy_src_r12: assert property (@(posedge clk) disable iff (!rst_n)
            stat_busy[k] |-> $past(|src_vld));
    end

    for (genvar p = 0; p < N_OUT; p++) begin : g_out
        p_mux_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(omux_sel[p]) >= N_STAGE) |-> (!out_vld[p] && out_rgb[p*36 +: 36] == '0));
    end

endmodule

bind blend_chain blend_chain_chk #(.N_STAGE(N_STAGE), .N_SRC(N_SRC), .N_OUT(N_OUT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_field (cfg_field),
    .cfg_index (cfg_index),
    .cfg_wdata (cfg_wdata),
    .cfg_all   (cfg_all),
    .omux_sel  (omux_sel),
    .src_vld   (src_vld),
    .out_vld   (out_vld),
    .out_rgb   (out_rgb),
    .stat_idle (stat_idle),
    .stat_busy (stat_busy)
);

// File: tb/blend_chain_bench.sv
module blend_chain_bench;

    localparam int N  = 4;
    localparam int NS = 4;
    localparam int NO = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [2:0]        cfg_field = '0;
    logic [3:0]        cfg_index = '0;
    logic [29:0]       cfg_wdata = '0;
    logic [29:0]       cfg_rdata;
    logic [NS-1:0]     src_vld = '0;
    logic [8*NS-1:0]   src_alpha = '0;
    logic [36*NS-1:0]  src_rgb = '0;
    logic [NO-1:0]     out_vld;
    logic [36*NO-1:0]  out_rgb;
    logic [N-1:0]      stat_idle, stat_busy;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    // shadow configuration and source state
    int sh_top[N], sh_bot[N], sh_mode[N], sh_am[N], sh_pm[N], sh_ov[N], sh_ga[N], sh_gg[N];
    int sh_bg[N][3];
    int sh_mux[NO];
    int s_vld[NS], s_a[NS], s_c[NS][3];
    int m_vld[N], m_c[N][3];

    always #2.5 clk = ~clk;

    blend_chain #(.N_STAGE(N), .N_SRC(NS), .N_OUT(NO)) u_blend_chain (.*);

    function automatic int mixm(int t, int b, int a, int pm);
        int r;
        r = ((pm != 0 ? t * 255 : t * a) + b * (255 - a)) / 255;
        return (r > 4095) ? 4095 : r;
    endfunction

    function automatic int effa(int am, int pa, int ga, int gg);
        if (am == 1) return ga;
        if (am == 2) return (pa * gg) / 255;
        return pa;
    endfunction

    task automatic model_settle();
        int nv[N];
        int nc[N][3];
        for (int it = 0; it < N + 2; it++) begin
            for (int k = 0; k < N; k++) begin
                bit tok, bok;
                int a, t;
                t   = sh_top[k];
                tok = (t < NS) && (s_vld[t < NS ? t : 0] != 0);
                bok = (sh_bot[k] < N) && (sh_bot[k] != k) && (m_vld[sh_bot[k] < N ? sh_bot[k] : 0] != 0);
                a   = effa(sh_am[k], t < NS ? s_a[t] : 0, sh_ga[k], sh_gg[k]);
                nv[k] = 0;
                for (int c = 0; c < 3; c++) nc[k][c] = sh_bg[k][c];
                if (sh_mode[k] == 0) begin
                    if (tok) begin
                        nv[k] = 1;
                        for (int c = 0; c < 3; c++) nc[k][c] = mixm(s_c[t][c], sh_bg[k][c], a, sh_pm[k]);
                    end
                end else if (sh_mode[k] == 1) begin
                    if (tok && bok) begin
                        nv[k] = 1;
                        for (int c = 0; c < 3; c++) nc[k][c] = mixm(s_c[t][c], m_c[sh_bot[k]][c], a, sh_pm[k]);
                    end else if (tok) begin
                        nv[k] = 1;
                        for (int c = 0; c < 3; c++)
                            nc[k][c] = (sh_ov[k] != 0) ? s_c[t][c] : mixm(s_c[t][c], sh_bg[k][c], a, sh_pm[k]);
                    end else if (bok) begin
                        nv[k] = 1;
                        for (int c = 0; c < 3; c++) nc[k][c] = m_c[sh_bot[k]][c];
                    end
                end else if (tok) begin
                    nv[k] = 1;
                    for (int c = 0; c < 3; c++) nc[k][c] = s_c[t][c];
                end
            end
            for (int k = 0; k < N; k++) begin
                m_vld[k] = nv[k];
                for (int c = 0; c < 3; c++) m_c[k][c] = nc[k][c];
            end
        end
    endtask

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic check_now(string tag);
        model_settle();
        for (int p = 0; p < NO; p++) begin
            int s, ev;
            int ec[3];
            s  = sh_mux[p];
            ev = (s < N) ? m_vld[s] : 0;
            for (int c = 0; c < 3; c++) ec[c] = (s < N) ? m_c[s][c] : 0;
            chk(tag, $sformatf("pipe%0d vld", p), int'(out_vld[p]), ev);
            chk(tag, $sformatf("pipe%0d rgb", p), int'(out_rgb[p*36 +: 36]),
                int'({ec[0][11:0], ec[1][11:0], ec[2][11:0]}));
        end
        for (int k = 0; k < N; k++) begin
            int eb;
            eb = (sh_top[k] < NS) ? s_vld[sh_top[k]] : 0;
            chk(tag, $sformatf("stage%0d busy", k), int'(stat_busy[k]), eb);
            chk(tag, $sformatf("stage%0d idle", k), int'(stat_idle[k]), 1 - eb);
        end
    endtask

    task automatic settle_check(string tag);
        repeat (N + 3) @(negedge clk);
        check_now(tag);
    endtask

    task automatic wr(int f, int idx, int data);
        cfg_we    = 1'b1;
        cfg_field = 3'(f);
        cfg_index = 4'(idx);
        cfg_wdata = 30'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic chk_rd(int f, int idx, int exp, string tag);
        cfg_field = 3'(f);
        cfg_index = 4'(idx);
        #1;
        chk(tag, $sformatf("rd f%0d i%0d", f, idx), int'(cfg_rdata), exp);
    endtask

    task automatic set_top(int k, int v);  wr(0, k, v); sh_top[k] = v; endtask
    task automatic set_bot(int k, int v);  wr(1, k, v); sh_bot[k] = v; endtask
    task automatic set_mux(int p, int v);  wr(6, p, v); if (p < NO) sh_mux[p] = v; endtask
    task automatic set_ctrl(int k, int md, int am, int pm, int ov);
        wr(2, k, (ov << 5) | (pm << 4) | (am << 2) | md);
        sh_mode[k] = md; sh_am[k] = am; sh_pm[k] = pm; sh_ov[k] = ov;
    endtask
    task automatic set_gain(int k, int ga, int gg);
        wr(3, k, (gg << 8) | ga); sh_ga[k] = ga; sh_gg[k] = gg;
    endtask
    task automatic set_bg(int k, int r, int g, int b);
        wr(5, k, (r << 20) | (g << 10) | b);
        sh_bg[k][0] = r << 2; sh_bg[k][1] = g << 2; sh_bg[k][2] = b << 2;
    endtask
    task automatic set_src(int i, int v, int a, int r, int g, int b);
        s_vld[i] = v; s_a[i] = a; s_c[i][0] = r; s_c[i][1] = g; s_c[i][2] = b;
        src_vld[i] = 1'(v);
        src_alpha[i*8 +: 8] = 8'(a);
        src_rgb[i*36 +: 36] = {12'(r), 12'(g), 12'(b)};
    endtask

    initial begin
        for (int k = 0; k < N; k++) begin
            sh_top[k] = 15; sh_bot[k] = 15; sh_mode[k] = 0; sh_am[k] = 0; sh_pm[k] = 0;
            sh_ov[k] = 0; sh_ga[k] = 255; sh_gg[k] = 255;
            for (int c = 0; c < 3; c++) begin sh_bg[k][c] = 0; m_c[k][c] = 0; end
            m_vld[k] = 0;
        end
        for (int p = 0; p < NO; p++) sh_mux[p] = 15;
        for (int i = 0; i < NS; i++) set_src(i, 0, 0, 0, 0, 0);
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: reset values seen through read-back and outputs
        for (int k = 0; k < N; k++) begin
            chk_rd(0, k, 'hF, "R2");
            chk_rd(1, k, 'hF, "R2");
            chk_rd(2, k, 0, "R2");
            chk_rd(3, k, 'hFFFF, "R2");
            chk_rd(4, k, 'hFF, "R2");
            chk_rd(5, k, 0, "R2");
        end
        for (int p = 0; p < NO; p++) chk_rd(6, p, 'hF, "R2");
        check_now("R2");

        // R1: write and read back in the stated layouts
        wr(4, 2, 'h3A);          chk_rd(4, 2, 'h3A, "R1");
        set_ctrl(3, 2, 3, 1, 1); chk_rd(2, 3, 'h3E, "R1");
        set_gain(1, 'h12, 'h34); chk_rd(3, 1, 'h3412, "R1");
        set_top(1, 2);           chk_rd(0, 1, 2, "R1");
        set_top(1, 15);
        set_ctrl(3, 0, 0, 0, 0);
        set_gain(1, 255, 255);

        // R3: background shifted by 2, valid low
        set_bg(0, 'h3FF, 'h155, 'h001);
        chk_rd(5, 0, ('h3FF << 20) | ('h155 << 10) | 1, "R3");
        set_mux(0, 0);
        settle_check("R3");

        // R4: top only over background, one-cycle latency
        set_src(0, 1, 128, 4000, 1000, 7);
        set_top(0, 0);
        settle_check("R4");
        set_src(0, 1, 64, 100, 2000, 4095);
        @(negedge clk);
        check_now("R4");

        // R13: top select beyond source count is disconnected
        set_top(0, 5);
        settle_check("R13");
        set_top(0, 0);

        // R8: alpha sources, premultiplied saturation
        set_gain(0, 100, 200);
        set_ctrl(0, 0, 1, 0, 0); settle_check("R8");
        set_ctrl(0, 0, 2, 0, 0); settle_check("R8");
        set_bg(0, 'h3FF, 'h3FF, 'h3FF);
        set_src(0, 1, 10, 4095, 4095, 4095);
        set_ctrl(0, 0, 0, 1, 0); settle_check("R8");

        // R5: two-level stack
        set_src(0, 1, 90, 3000, 500, 1200);
        set_src(1, 1, 200, 800, 3500, 60);
        set_top(1, 1);
        set_ctrl(1, 2, 0, 0, 0);
        set_ctrl(0, 1, 0, 0, 0);
        set_bot(0, 1);
        settle_check("R5");

        // R9: overlap-only with missing bottom
        set_top(1, 15);
        set_ctrl(0, 1, 0, 0, 1);
        settle_check("R9");

        // R10: missing top, valid bottom
        set_top(1, 1);
        set_top(0, 15);
        settle_check("R10");

        // R6: disconnected bottom variants
        set_top(0, 0);
        set_ctrl(0, 1, 0, 0, 0);
        set_bot(0, 0);  settle_check("R6");
        set_bot(0, 9);  settle_check("R6");
        set_bot(0, 15); settle_check("R6");

        // R7: passthrough and spare code
        set_ctrl(0, 2, 1, 0, 0); settle_check("R7");
        set_ctrl(0, 3, 0, 1, 0); settle_check("R7");

        // R11: output selectors
        set_mux(1, 1);  settle_check("R11");
        set_mux(1, 9);  settle_check("R11");
        set_mux(0, 15); settle_check("R11");

        // R12: status bits
        set_src(0, 0, 0, 0, 0, 0); settle_check("R12");
        set_src(0, 1, 50, 10, 20, 30); settle_check("R12");
        set_top(0, 15);
        check_now("R12");

        // random acyclic stacks (R5 and the rest together)
        for (int it = 0; it < 60; it++) begin
            for (int k = 0; k < N; k++) begin
                int r, b;
                r = $urandom_range(0, 5);
                set_top(k, r < 4 ? r : (r == 4 ? 15 : 5));
                r = $urandom_range(0, 3);
                if (r == 0) b = 15;
                else if (r == 1) b = k;
                else if (r == 2) b = 9;
                else b = (k + 1 < N) ? $urandom_range(k + 1, N - 1) : 15;
                set_bot(k, b);
                set_ctrl(k, $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 1),
                         $urandom_range(0, 1));
                set_gain(k, $urandom_range(0, 255), $urandom_range(0, 255));
                set_bg(k, $urandom_range(0, 1023), $urandom_range(0, 1023), $urandom_range(0, 1023));
            end
            for (int i = 0; i < NS; i++)
                set_src(i, $urandom_range(0, 3) != 0, $urandom_range(0, 255), $urandom_range(0, 4095),
                        $urandom_range(0, 4095), $urandom_range(0, 4095));
            for (int p = 0; p < NO; p++) set_mux(p, $urandom_range(0, 5));
            settle_check("R5");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule